// File: doc/BRIEF.md
# Static Memory Bank Timing Sequencer

This block turns single internal read or write requests into timed cycles on an external asynchronous static memory or peripheral bus. The bus is shared by four banks, and each bank has its own chip-select line. Each bank also has its own timing set, data width and page mode. The per-bank settings come in as static configuration words, one per bank.

A request carries a bank number, a byte offset, a direction and write data. It is accepted with a valid/ready handshake while the block is idle. The sequencer then walks a fixed list of phases on the bus:

1. It drives the address and waits out the address setup time.
2. It lowers the bank's chip select and waits out the chip-select setup time.
3. It asserts the read or write strobe for the access time.
4. It releases the strobe and keeps chip select low for the hold time.
5. It releases chip select and keeps the address for the address hold time.

A read returns its data with a one-cycle valid pulse for each beat. The end of every request is marked by a one-cycle done pulse. A bank in page mode turns a read into a four-beat burst under a single chip-select assertion.

Top module: `smem_bank_seq`

## Requirements
- R1: After reset, and while the reset input is low, the following hold: ready is high, all four chip selects are high, the read strobe is high, the write strobe is high, the data-drive flag is low, and neither the read-valid pulse nor the done pulse is high.
- R2: Ready is high only while idle. A request is taken on a clock edge where valid and ready are both high. Ready stays low from the cycle after acceptance until the done cycle.
- R3: After acceptance the address shows the request offset with every chip select high, for exactly the address setup count of cycles. The selected chip select is then low with both strobes high for exactly the chip-select setup count of cycles.
- R4: An access field value of N holds the strobe low for N+1 consecutive cycles. The field is 5 bits, so the strobe lasts 1 to 32 cycles.
- R5: After the strobe rises, chip select stays low for the hold count of cycles. Chip select then stays high with the block still busy for the address hold count of cycles. In the next cycle the done output is high for one cycle and the block is idle.
- R6: A timing field of zero adds no cycles. A bank whose fields are all zero completes a request in a single busy cycle, which is the strobe cycle.
- R7: Only the chip select of the requested bank ever goes low, where bank n drives chip-select bit n. It does not change while it is low.
- R8: On a read the write strobe stays high and the block does not drive the data bus. The bus is sampled in the last strobe cycle of each beat, and the result appears with a one-cycle read-valid pulse in the following cycle. A 2-byte bank returns the full 16 bits. A 1-byte bank returns bus bits 7:0 with the upper byte zero.
- R9: On a write the write strobe replaces the read strobe, and the read strobe stays high. The data-drive flag is high, and the bus carries the write data, in exactly the cycles where chip select is low. No read-valid pulse is produced.
- R10: A page-mode read makes four beats with chip select held low and the strobe held low throughout. The first beat lasts the access time. Each later beat lasts the page access count, or one cycle when that count is zero. The address rises by 1 on a 1-byte bank or 2 on a 2-byte bank at each beat, and four read-valid pulses result.
- R11: The page-mode bit has no effect on writes. A write to a page-mode bank makes a single strobe of the access time.
- R12: Bank n's configuration word sits in bits [27n+26:27n] of the configuration input. Within a word the bits are laid out as follows: bits 3:0 address setup, 7:4 chip-select setup, 12:8 access, 16:13 chip-select hold, 20:17 address hold, 24:21 page access time, 25 width (1 = 2 bytes, 0 = 1 byte), and 26 page mode (1 = four-beat page).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_bank_i | input | 2 | Target bank |
| req_offset_i | input | 24 | Byte offset driven on the address bus |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | One-cycle pulse per returned read beat |
| rsp_rdata_o | output | 16 | Read data, right-aligned |
| done_o | output | 1 | One-cycle pulse when a request has finished |
| bank_cfg_i | input | 108 | Static per-bank configuration words |
| mem_addr_o | output | 24 | External address bus |
| mem_cs_no | output | 4 | Chip selects, active low, one per bank |
| mem_oe_no | output | 1 | Read strobe, active low |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_data_io | inout | 16 | Bidirectional data bus |
| mem_data_oe_o | output | 1 | High while the block drives the data bus |

## Verification
The bench builds the block with its default parameters: four banks, a 24-bit address and a 16-bit data bus. Those values give it every chip-select line and both data widths, and let a page burst on a wide bank step through even addresses.

The bench gives each bank a contrasting timing set:
- one bank has all fields at zero, for the single-cycle path;
- one has the 32-cycle access time together with the longest hold;
- one has mixed nonzero phases;
- one has the longest address setup and uses page mode.

One bank is later reprogrammed to page mode with a zero page time, which exercises the one-cycle beat floor.

// File: rtl/smem_seq_pkg.sv
package smem_seq_pkg;
  localparam int TW    = 4;
  localparam int ACC_W = 5;
  localparam int CNT_W = 5;
  localparam int CFG_W = 2 + 5 * TW + ACC_W;

  typedef struct packed {
    logic             page;
    logic             wide;
    logic [TW-1:0]    t_pa;
    logic [TW-1:0]    t_ah;
    logic [TW-1:0]    t_ch;
    logic [ACC_W-1:0] t_acc;
    logic [TW-1:0]    t_cs;
    logic [TW-1:0]    t_as;
  } bank_cfg_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ASETUP,
    PH_CSSETUP,
    PH_STROBE,
    PH_CSHOLD,
    PH_AHOLD
  } phase_e;
endpackage

// File: rtl/smem_cfg_sel.sv
module smem_cfg_sel
  import smem_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic [NUM_BANKS*CFG_W-1:0] cfg_words_i,
  input  logic [BANK_W-1:0]          sel_i,
  output bank_cfg_t                  cfg_o
);
  bank_cfg_t cfg_arr [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_unpack
    assign cfg_arr[g] = bank_cfg_t'(cfg_words_i[g*CFG_W +: CFG_W]);
  end

  assign cfg_o = cfg_arr[sel_i];
endmodule

// File: rtl/smem_cs_dec.sv
module smem_cs_dec #(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 en_i,
  input  logic [BANK_W-1:0]    sel_i,
  output logic [NUM_BANKS-1:0] cs_no
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cs
    assign cs_no[g] = !(en_i && (sel_i == BANK_W'(g)));
  end
endmodule

// File: rtl/smem_phase_fsm.sv
module smem_phase_fsm
  import smem_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             page_en_i,
  input  logic [TW-1:0]    t_as_i,
  input  logic [TW-1:0]    t_cs_i,
  input  logic [ACC_W-1:0] t_acc_i,
  input  logic [TW-1:0]    t_ch_i,
  input  logic [TW-1:0]    t_ah_i,
  input  logic [TW-1:0]    t_pa_i,
  output phase_e           phase_o,
  output logic             beat_end_o,
  output logic             adv_o,
  output logic             done_o
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       beat_q, beat_d;
  logic             done_q, done_d;

  logic [CNT_W-1:0] as_m1, cs_m1, ch_m1, ah_m1, pa_ld, acc_ld;
  assign as_m1  = CNT_W'(t_as_i) - CNT_W'(1);
  assign cs_m1  = CNT_W'(t_cs_i) - CNT_W'(1);
  assign ch_m1  = CNT_W'(t_ch_i) - CNT_W'(1);
  assign ah_m1  = CNT_W'(t_ah_i) - CNT_W'(1);
  assign pa_ld  = (t_pa_i == '0) ? '0 : CNT_W'(t_pa_i) - CNT_W'(1);
  assign acc_ld = CNT_W'(t_acc_i);

  logic cnt_zero;
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    beat_d     = beat_q;
    done_d     = 1'b0;
    beat_end_o = 1'b0;
    adv_o      = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          beat_d = '0;
          if (t_as_i != '0) begin
            phase_d = PH_ASETUP;  cnt_d = as_m1;
          end else if (t_cs_i != '0) begin
            phase_d = PH_CSSETUP; cnt_d = cs_m1;
          end else begin
            phase_d = PH_STROBE;  cnt_d = acc_ld;
          end
        end
      end
      PH_ASETUP: begin
        if (!cnt_zero) cnt_d = cnt_q - 1'b1;
        else if (t_cs_i != '0) begin
          phase_d = PH_CSSETUP; cnt_d = cs_m1;
        end else begin
          phase_d = PH_STROBE;  cnt_d = acc_ld;
        end
      end
      PH_CSSETUP: begin
        if (!cnt_zero) cnt_d = cnt_q - 1'b1;
        else begin
          phase_d = PH_STROBE; cnt_d = acc_ld;
        end
      end
      PH_STROBE: begin
        if (!cnt_zero) cnt_d = cnt_q - 1'b1;
        else begin
          beat_end_o = 1'b1;
          if (page_en_i && beat_q != 2'd3) begin
            // page beat: strobe stays low, address steps
            beat_d = beat_q + 1'b1;
            cnt_d  = pa_ld;
            adv_o  = 1'b1;
          end else if (t_ch_i != '0) begin
            phase_d = PH_CSHOLD; cnt_d = ch_m1;
          end else if (t_ah_i != '0) begin
            phase_d = PH_AHOLD;  cnt_d = ah_m1;
          end else begin
            phase_d = PH_IDLE;   done_d = 1'b1;
          end
        end
      end
      PH_CSHOLD: begin
        if (!cnt_zero) cnt_d = cnt_q - 1'b1;
        else if (t_ah_i != '0) begin
          phase_d = PH_AHOLD; cnt_d = ah_m1;
        end else begin
          phase_d = PH_IDLE;  done_d = 1'b1;
        end
      end
      PH_AHOLD: begin
        if (!cnt_zero) cnt_d = cnt_q - 1'b1;
        else begin
          phase_d = PH_IDLE; done_d = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      beat_q  <= beat_d;
      done_q  <= done_d;
    end
  end

  assign phase_o = phase_q;
  assign done_o  = done_q;
endmodule

// File: rtl/smem_bank_seq.sv
module smem_bank_seq
  import smem_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  output logic                       req_ready_o,
  input  logic [BANK_W-1:0]          req_bank_i,
  input  logic [ADDR_W-1:0]          req_offset_i,
  input  logic                       req_write_i,
  input  logic [DATA_W-1:0]          req_wdata_i,
  output logic                       rsp_valid_o,
  output logic [DATA_W-1:0]          rsp_rdata_o,
  output logic                       done_o,
  input  logic [NUM_BANKS*CFG_W-1:0] bank_cfg_i,
  output logic [ADDR_W-1:0]          mem_addr_o,
  output logic [NUM_BANKS-1:0]       mem_cs_no,
  output logic                       mem_oe_no,
  output logic                       mem_we_no,
  inout  wire  [DATA_W-1:0]          mem_data_io,
  output logic                       mem_data_oe_o
);
  phase_e              phase;
  bank_cfg_t           cfg;
  logic [BANK_W-1:0]   bank_q, sel_bank;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q, rdata_q, rd_sample;
  logic                write_q, rsp_valid_q;
  logic                accept, beat_end, adv, cs_active, strobe, fsm_done;

  assign req_ready_o = (phase == PH_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign sel_bank    = req_ready_o ? req_bank_i : bank_q;

  smem_cfg_sel #(.NUM_BANKS(NUM_BANKS)) u_cfg_sel (
    .cfg_words_i (bank_cfg_i),
    .sel_i       (sel_bank),
    .cfg_o       (cfg)
  );

  smem_phase_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .page_en_i  (cfg.page && !write_q),
    .t_as_i     (cfg.t_as),
    .t_cs_i     (cfg.t_cs),
    .t_acc_i    (cfg.t_acc),
    .t_ch_i     (cfg.t_ch),
    .t_ah_i     (cfg.t_ah),
    .t_pa_i     (cfg.t_pa),
    .phase_o    (phase),
    .beat_end_o (beat_end),
    .adv_o      (adv),
    .done_o     (fsm_done)
  );

  assign cs_active = (phase == PH_CSSETUP) || (phase == PH_STROBE) || (phase == PH_CSHOLD);
  assign strobe    = (phase == PH_STROBE);

  smem_cs_dec #(.NUM_BANKS(NUM_BANKS)) u_cs_dec (
    .en_i  (cs_active),
    .sel_i (bank_q),
    .cs_no (mem_cs_no)
  );

  assign mem_oe_no     = !(strobe && !write_q);
  assign mem_we_no     = !(strobe && write_q);
  assign mem_data_oe_o = cs_active && write_q;
  assign mem_data_io   = mem_data_oe_o ? wdata_q : {DATA_W{1'bz}};
  assign mem_addr_o    = addr_q;

  assign rd_sample = cfg.wide ? mem_data_io : {{(DATA_W-8){1'b0}}, mem_data_io[7:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q      <= '0;
      addr_q      <= '0;
      write_q     <= 1'b0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= beat_end && !write_q;
      if (accept) begin
        bank_q  <= req_bank_i;
        addr_q  <= req_offset_i;
        write_q <= req_write_i;
        wdata_q <= req_wdata_i;
      end else if (adv) begin
        addr_q <= addr_q + (cfg.wide ? ADDR_W'(2) : ADDR_W'(1));
      end
      if (beat_end && !write_q) rdata_q <= rd_sample;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rdata_q;
  assign done_o      = fsm_done;

  AST_ONE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~mem_cs_no) <= 1) else $error("AST_ONE_CS"); // R7
  AST_CS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(mem_cs_no) != '1) && (mem_cs_no != '1)) |-> (mem_cs_no == $past(mem_cs_no)))
    else $error("AST_CS_STABLE"); // R7
  AST_STROBE_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no || !mem_we_no) |-> (mem_cs_no != '1)) else $error("AST_STROBE_IN_CS"); // R3
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no)) else $error("AST_ONE_STROBE"); // R9
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_data_oe_o) else $error("AST_NO_DRIVE_ON_READ"); // R8
  AST_READY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o) else $error("AST_READY_DROPS"); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("AST_DONE_PULSE"); // R5
  AST_RSP_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) |-> $past(!mem_oe_no)) else $error("AST_RSP_AFTER_READ"); // R8
endmodule

// File: tb/smem_bank_seq_bench.sv
`timescale 1ns/1ps
module smem_bank_seq_bench;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic [1:0]   req_bank_i = '0;
  logic [23:0]  req_offset_i = '0;
  logic         req_write_i = 1'b0;
  logic [15:0]  req_wdata_i = '0;
  logic         rsp_valid_o;
  logic [15:0]  rsp_rdata_o;
  logic         done_o;
  logic [107:0] bank_cfg_i = '0;
  logic [23:0]  mem_addr_o;
  logic [3:0]   mem_cs_no;
  logic         mem_oe_no, mem_we_no, mem_data_oe_o;
  wire  [15:0]  mem_bus;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] mdl(input logic [23:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  assign mem_bus = (!mem_oe_no && !mem_data_oe_o) ? mdl(mem_addr_o) : 16'hzzzz;

  smem_bank_seq u_smem_bank_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_bank_i(req_bank_i), .req_offset_i(req_offset_i),
    .req_write_i(req_write_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .done_o(done_o),
    .bank_cfg_i(bank_cfg_i),
    .mem_addr_o(mem_addr_o), .mem_cs_no(mem_cs_no),
    .mem_oe_no(mem_oe_no), .mem_we_no(mem_we_no),
    .mem_data_io(mem_bus), .mem_data_oe_o(mem_data_oe_o)
  );

  int cas[4], ccs[4], cacc[4], cch[4], cah[4], cpa[4];
  bit cw[4], cpg[4];

  // R12 field layout: {page, wide, pa, ah, ch, acc, cs, as}
  task automatic apply_cfg();
    for (int b = 0; b < 4; b++)
      bank_cfg_i[b*27 +: 27] = {cpg[b], cw[b], 4'(cpa[b]), 4'(cah[b]), 4'(cch[b]),
                                5'(cacc[b]), 4'(ccs[b]), 4'(cas[b])};
  endtask

  task automatic set_bank(input int b, input int a_s, input int c_s, input int acc,
                          input int c_h, input int a_h, input int pa, input bit w, input bit pg);
    cas[b] = a_s; ccs[b] = c_s; cacc[b] = acc; cch[b] = c_h; cah[b] = a_h;
    cpa[b] = pa; cw[b] = w; cpg[b] = pg;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [1:0] b, input logic wr, input logic [23:0] off,
                         input logic [15:0] wd, output int total, output int nstr, output int nrsp);
    int s0, s1, s3, s4, step, pl, expstr, beat;
    bit seen_str, bad_cs, bad_a0, bad_pa, bad_wr, bad_rd, bad_rdy, bad_pol, hung;
    logic [15:0] e;
    logic [23:0] ea;
    s0 = 0; s1 = 0; s3 = 0; s4 = 0; total = 0; nstr = 0; nrsp = 0;
    seen_str = 0; bad_cs = 0; bad_a0 = 0; bad_pa = 0; bad_wr = 0; bad_rd = 0;
    bad_rdy = 0; bad_pol = 0; hung = 1;
    step = cw[b] ? 2 : 1;
    pl = (cpa[b] == 0) ? 1 : cpa[b];
    expstr = cacc[b] + 1 + ((cpg[b] && !wr) ? 3 * pl : 0);
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R2", int'(req_ready_o), 1);
    req_valid_i = 1'b1; req_bank_i = b; req_write_i = wr;
    req_offset_i = off; req_wdata_i = wd;
    @(negedge clk);
    req_valid_i = 1'b0;
    for (int it = 0; it < 3000; it++) begin
      if (rsp_valid_o) begin
        ea = off + 24'(nrsp * step);
        e = cw[b] ? mdl(ea) : {8'h00, mdl(ea)[7:0]};
        if (rsp_rdata_o !== e) bad_rd = 1;
        nrsp++;
      end
      if (done_o) begin hung = 0; break; end
      total++;
      if (req_ready_o) bad_rdy = 1;
      if (mem_cs_no != 4'hF && mem_cs_no != ~(4'b1 << b)) bad_cs = 1;
      if (!mem_oe_no || !mem_we_no) begin
        beat = (nstr < cacc[b] + 1) ? 0 : 1 + (nstr - cacc[b] - 1) / pl;
        if (mem_addr_o != off + 24'(beat * step)) bad_pa = 1;
        if (mem_cs_no == 4'hF) bad_cs = 1;
        if (wr ? (mem_we_no || !mem_oe_no) : (mem_oe_no || !mem_we_no)) bad_pol = 1;
        nstr++;
        seen_str = 1;
      end else if (!seen_str) begin
        if (mem_cs_no != 4'hF) s1++;
        else begin
          s0++;
          if (mem_addr_o != off) bad_a0 = 1;
        end
      end else begin
        if (mem_cs_no != 4'hF) s3++; else s4++;
      end
      if (wr) begin
        if ((mem_cs_no != 4'hF) != mem_data_oe_o) bad_wr = 1;
        if (mem_cs_no != 4'hF && mem_bus !== wd) bad_wr = 1;
      end else if (mem_data_oe_o) bad_wr = 1;
      @(negedge clk);
    end
    chk(!hung, "R5", int'(hung), 0);
    chk(!bad_rdy, "R2", int'(bad_rdy), 0);
    chk(s0 == cas[b] && !bad_a0, "R3", s0, cas[b]);
    chk(s1 == ccs[b], "R3", s1, ccs[b]);
    chk(nstr == expstr, "R4", nstr, expstr);
    chk(s3 == cch[b], "R5", s3, cch[b]);
    chk(s4 == cah[b], "R5", s4, cah[b]);
    chk(!bad_cs, "R7", mem_cs_no, ~(4'b1 << b));
    chk(!bad_pa, "R10", int'(bad_pa), 0);
    if (wr) begin
      chk(!bad_wr && !bad_pol, "R9", {bad_wr, bad_pol}, 0);
      chk(nrsp == 0, "R9", nrsp, 0);
    end else begin
      chk(!bad_rd && !bad_pol && !bad_wr, "R8", {bad_rd, bad_pol, bad_wr}, 0);
      chk(nrsp == (cpg[b] ? 4 : 1), "R8", nrsp, cpg[b] ? 4 : 1);
    end
  endtask

  // {bank, write, offset, wdata}
  localparam logic [42:0] VEC [8] = '{
    {2'd0, 1'b0, 24'h000010, 16'h0000},
    {2'd0, 1'b1, 24'h000011, 16'h00A5},
    {2'd1, 1'b0, 24'h001234, 16'h0000},
    {2'd1, 1'b1, 24'h00FFFE, 16'hBEEF},
    {2'd2, 1'b0, 24'h0000FF, 16'h0000},
    {2'd3, 1'b0, 24'h000100, 16'h0000},
    {2'd3, 1'b1, 24'h000200, 16'h1357},
    {2'd2, 1'b1, 24'h123456, 16'hC0DE}
  };

  task automatic check_reset_state(input string tag);
    chk({mem_cs_no, mem_oe_no, mem_we_no, mem_data_oe_o, rsp_valid_o, done_o, req_ready_o}
        == {4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, tag,
        {mem_cs_no, mem_oe_no, mem_we_no, mem_data_oe_o, rsp_valid_o, done_o, req_ready_o},
        {4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int tot, ns, nr;
    set_bank(0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0);
    set_bank(1, 2, 3, 4, 1, 2, 0, 1'b1, 1'b0);
    set_bank(2, 1, 0, 31, 15, 0, 0, 1'b0, 1'b0);
    set_bank(3, 15, 1, 2, 2, 1, 3, 1'b1, 1'b1);
    apply_cfg();
    #12;
    check_reset_state("R1");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_reset_state("R1");

    for (int i = 0; i < 8; i++) begin
      run_txn(VEC[i][42:41], VEC[i][40], VEC[i][39:16], VEC[i][15:0], tot, ns, nr);
      if (i == 0) chk(tot == 1, "R6", tot, 1);
      if (i == 4) chk(ns == 32, "R12", ns, 32);
      if (i == 6) chk(ns == 3 && nr == 0, "R11", ns, 3);
    end

    // page read, zero page time, byte bank: one-cycle beats
    set_bank(0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b1);
    apply_cfg();
    run_txn(2'd0, 1'b0, 24'h000040, 16'h0000, tot, ns, nr);
    chk(ns == 4 && nr == 4, "R10", ns, 4);
    chk(tot == 4, "R6", tot, 4);
    set_bank(0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0);
    apply_cfg();

    // reset in the middle of a long access
    @(negedge clk);
    req_valid_i = 1'b1; req_bank_i = 2'd2; req_write_i = 1'b1;
    req_offset_i = 24'h000777; req_wdata_i = 16'h4242;
    @(negedge clk);
    req_valid_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(mem_we_no == 1'b0, "R9", int'(mem_we_no), 0);
    rst_ni = 1'b0;
    #1;
    check_reset_state("R1");
    @(negedge clk);
    rst_ni = 1'b1;
    run_txn(2'd1, 1'b0, 24'h000020, 16'h0000, tot, ns, nr);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule